// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This block is a counter driven by the main system clock. Software sets it up as either a periodic interval timer or a watchdog. The period is always a power of two. It is picked through a 3-bit select code. The count is split into two parts. The low part is a free-running prescaler that is never cleared by software. The high part is an interval counter that a start write clears. For this reason the first period after a start can fall short of the selected period by up to one prescaler span.

In interval mode the block sends a one-cycle, maskable request toward the interrupt controller at every expiry. After that the count restarts by itself. In watchdog mode an expiry sets a sticky overflow flag, which only a reset clears. Software keeps this flag from setting by rewriting the run bit before each expiry. Once watchdog mode has been selected, it cannot be left until reset. Counting pauses while the part is in its stop power state or while the CPU runs from the subsystem clock. Counting carries on in the halt state.

Top module: `wdt_dual_timer`

## Requirements
- R1: After reset both outputs are low, the run bit is 0, interval mode is active and the select code is 0. As a result, a run write with no select write gives a period of 2^BASE_EXP cycles.
- R2: The select register is written with wr_addr_i=1 and wr_data_i[2:0]. Codes 0 to 6 select 2^(BASE_EXP+code) cycles. Code 7 selects 2^(BASE_EXP+6+TOP_GAP) cycles. With the defaults, this gives 2^12 to 2^18 cycles for codes 0 to 6 and 2^20 cycles for code 7.
- R3: In interval mode, every expiry produces a pulse on intv_irq_o exactly one cycle wide. Further pulses follow every period without any software action.
- R4: A mode write (wr_addr_i=0) with wr_data_i[0]=1 sets the run bit and clears the interval counter, but not the prescaler. Let p be the prescaler value after that write edge, which is the number of enabled cycles since reset modulo 2^PRE_BITS. The first expiry then comes 2^E - p enabled cycles after the write.
- R5: While the run bit is 0 (mode write with wr_data_i[0]=0), the interval counter is held at zero and neither output is raised.
- R6: While irq_mask_i is 1, expiries raise no request. Counting continues, so later requests stay on the original period grid.
- R7: The prescaler and the counter freeze while pwr_mode_i is 2'b10 (stop) or 2'b11, or while subclk_i is 1. They count while pwr_mode_i is 2'b00 (run) or 2'b01 (halt).
- R8: Watchdog mode is selected by a mode write with wr_data_i[1]=1. After that, mode writes with wr_data_i[1]=0 leave the block in watchdog mode. Only reset returns it to interval mode.
- R9: In watchdog mode an expiry sets wd_ovf_o, which stays high until reset, and intv_irq_o never pulses. A run write before expiry restarts the count, which prevents the overflow.
- R10: Expiry is tested as counter >= limit at a prescaler wrap. If a shorter code is selected while the counter is already past the new limit, expiry occurs at the next prescaler wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 selects the mode register, 1 selects the period-select register |
| wr_data_i | input | 3 | Write data: mode bit0 is run and bit1 is watchdog; for select, bits 2:0 are the code |
| irq_mask_i | input | 1 | Mask flag for the interval request |
| pwr_mode_i | input | 2 | Power state: 00 run, 01 halt, 10 stop, 11 stop |
| subclk_i | input | 1 | CPU is running from the subsystem clock |
| intv_irq_o | output | 1 | One-cycle maskable interval request |
| wd_ovf_o | output | 1 | Sticky watchdog overflow |

## Verification
A wrong internal count shows up at the ports as a pulse or an overflow on the wrong enabled-cycle count. The offset appears at the first expiry, within one period of the start. The bench therefore predicts each expiry from its own tally of enabled cycles and the selected exponent. A wrong prescaler phase or a wrong clear on start breaks the 2^E - p formula at the first pulse. A lost mode lock or a lost sticky flag shows up within one period as a stray request or a dropped overflow. A counter that ignores a freeze shows up as an early pulse inside the freeze window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'b00,
    PWR_HALT = 2'b01,
    PWR_STOP = 2'b10,
    PWR_DEEP = 2'b11
  } pwr_mode_e;

  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_SEL  = 1'b1;

  // Exponent of the period for a select code: linear steps, last code jumps.
  function automatic int unsigned period_exp(input logic [2:0] code,
                                             input int unsigned base_exp,
                                             input int unsigned top_gap);
    if (code == 3'd7) return base_exp + 6 + top_gap;
    return base_exp + 32'(code);
  endfunction

  function automatic int unsigned max_exp(input int unsigned base_exp,
                                          input int unsigned top_gap);
    return base_exp + 6 + top_gap;
  endfunction

endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs import wdt_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_addr_i,
  input  logic [2:0] wr_data_i,
  output logic       run_o,
  output logic       wd_mode_o,
  output logic [2:0] sel_o,
  output logic       start_clr_o
);

  logic       run_q;
  logic       wd_mode_q;
  logic [2:0] sel_q;

  assign start_clr_o = wr_en_i && (wr_addr_i == ADDR_MODE) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      wd_mode_q <= 1'b0;
      sel_q     <= 3'd0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_MODE) begin
        run_q     <= wr_data_i[0];
        wd_mode_q <= wd_mode_q | wr_data_i[1];
      end else begin
        sel_q <= wr_data_i;
      end
    end
  end

  assign run_o     = run_q;
  assign wd_mode_o = wd_mode_q;
  assign sel_o     = sel_q;

  // R8: watchdog selection is one-way until reset
  assert_mode_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_mode_q |=> wd_mode_q);

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PRE_BITS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cnt_en_i,
  output logic                wrap_o
);

  logic [PRE_BITS-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_q <= '0;
    else if (cnt_en_i) pre_q <= pre_q + 1'b1;
  end

  assign wrap_o = cnt_en_i && (&pre_q);

  // R7: no prescaler movement while counting is gated off
  assert_pre_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> $stable(pre_q));

endmodule

// File: rtl/wdt_interval_counter.sv
module wdt_interval_counter import wdt_pkg::*; #(
  parameter int unsigned PRE_BITS = 8,
  parameter int unsigned BASE_EXP = 12,
  parameter int unsigned TOP_GAP  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       start_clr_i,
  input  logic       pre_wrap_i,
  input  logic [2:0] sel_i,
  output logic       period_hit_o
);

  localparam int unsigned MAX_EXP = max_exp(BASE_EXP, TOP_GAP);
  localparam int unsigned UP_W    = MAX_EXP - PRE_BITS;

  logic [UP_W-1:0] up_q;
  logic [UP_W-1:0] limit;
  int unsigned     shift;

  always_comb begin
    shift = period_exp(sel_i, BASE_EXP, TOP_GAP) - PRE_BITS;
    limit = ~({UP_W{1'b1}} << shift);
  end

  assign period_hit_o = run_i && pre_wrap_i && !start_clr_i && (up_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    up_q <= '0;
    else if (start_clr_i || !run_i) up_q <= '0;
    else if (period_hit_o)          up_q <= '0;
    else if (pre_wrap_i)            up_q <= up_q + 1'b1;
  end

  // R5: an idle timer keeps its counter at zero
  assert_idle_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (up_q == '0));

  // R4: a start write leaves the counter at zero
  assert_start_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_clr_i |=> (up_q == '0));

  // R7: running counter holds when no prescaler wrap arrives
  assert_up_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !pre_wrap_i && !start_clr_i) |=> $stable(up_q));

endmodule

// File: rtl/wdt_dual_timer.sv
module wdt_dual_timer import wdt_pkg::*; #(
  parameter int unsigned PRE_BITS = 8,
  parameter int unsigned BASE_EXP = 12,
  parameter int unsigned TOP_GAP  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_addr_i,
  input  logic [2:0] wr_data_i,
  input  logic       irq_mask_i,
  input  logic [1:0] pwr_mode_i,
  input  logic       subclk_i,
  output logic       intv_irq_o,
  output logic       wd_ovf_o
);

  logic       run;
  logic       wd_mode;
  logic [2:0] sel;
  logic       start_clr;
  logic       cnt_en;
  logic       pre_wrap;
  logic       period_hit;
  logic       irq_q;
  logic       ovf_q;
  pwr_mode_e  pwr;

  assign pwr    = pwr_mode_e'(pwr_mode_i);
  assign cnt_en = ((pwr == PWR_RUN) || (pwr == PWR_HALT)) && !subclk_i;

  wdt_ctrl_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .run_o       (run),
    .wd_mode_o   (wd_mode),
    .sel_o       (sel),
    .start_clr_o (start_clr)
  );

  wdt_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_en_i (cnt_en),
    .wrap_o   (pre_wrap)
  );

  wdt_interval_counter #(
    .PRE_BITS (PRE_BITS),
    .BASE_EXP (BASE_EXP),
    .TOP_GAP  (TOP_GAP)
  ) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .start_clr_i  (start_clr),
    .pre_wrap_i   (pre_wrap),
    .sel_i        (sel),
    .period_hit_o (period_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      irq_q <= period_hit && !wd_mode && !irq_mask_i;
      ovf_q <= ovf_q | (period_hit && wd_mode);
    end
  end

  assign intv_irq_o = irq_q;
  assign wd_ovf_o   = ovf_q;

  // R3: the interval request is a single-cycle pulse
  assert_irq_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intv_irq_o |=> !intv_irq_o);

  // R9: overflow is sticky until reset
  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_ovf_o |=> wd_ovf_o);

  // R9: no interval request while watchdog mode was active
  assert_irq_not_wd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(intv_irq_o) |-> !$past(wd_mode));

  // R6: a masked expiry raises no request
  assert_irq_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(intv_irq_o) |-> !$past(irq_mask_i));

  // R5: an idle timer raises nothing
  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !$rose(intv_irq_o) && !$rose(wd_ovf_o));

endmodule

// File: tb/test_wdt_dual_timer.sv
`timescale 1ns/1ps
module test_wdt_dual_timer;

  localparam int PRE  = 2;
  localparam int BASE = 3;
  localparam int GAP  = 2;
  localparam int M    = 1 << PRE;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [2:0] wr_data = 3'd0;
  logic       mask = 1'b0;
  logic [1:0] pwr = 2'b00;
  logic       subclk = 1'b0;
  logic       irq;
  logic       ovf;

  int checks = 0;
  int fails  = 0;
  int en_cnt = 0;
  int irq_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdt_dual_timer #(.PRE_BITS(PRE), .BASE_EXP(BASE), .TOP_GAP(GAP)) i_wdt_dual_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .irq_mask_i(mask), .pwr_mode_i(pwr),
    .subclk_i(subclk), .intv_irq_o(irq), .wd_ovf_o(ovf));

  // bench tally of enabled clock edges since reset (prescaler phase, R4/R7)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_cnt <= 0;
    else if (!pwr[1] && !subclk) en_cnt <= en_cnt + 1;
  end

  always @(negedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  function automatic int exp_of(input int code);
    return (code == 7) ? BASE + 6 + GAP : BASE + code;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic a, input logic [2:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_irq(input int base, input int expd, input string req);
    int n = 0;
    bit got = 0;
    while (!got && n < 6000) begin
      @(posedge clk); @(negedge clk); n++;
      if (irq) got = 1;
    end
    check(got && (en_cnt - base) == expd, req, got ? en_cnt - base : -1, expd);
  endtask

  task automatic wait_ovf(input int base, input int expd, input string req);
    int n = 0;
    bit got = 0;
    while (!got && n < 6000) begin
      @(posedge clk); @(negedge clk); n++;
      if (ovf) got = 1;
    end
    check(got && (en_cnt - base) == expd, req, got ? en_cnt - base : -1, expd);
  endtask

  initial begin
    int base;
    int c;
    do_reset();
    @(negedge clk);
    // R1: reset state of outputs
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    check(ovf == 1'b0, "R1 ovf after reset", ovf, 0);

    // R5: not started, nothing happens
    c = irq_cnt;
    repeat (300) @(negedge clk);
    check(irq_cnt == c && ovf == 1'b0, "R5 idle after reset", irq_cnt - c, 0);

    // R1: default code 0 period without a select write
    wr(1'b0, 3'b001);
    base = en_cnt;
    wait_irq(base, (1 << BASE) - base % M, "R1 default period");

    // R2 R3 R4: sweep all codes, varying prescaler phase
    for (int code = 0; code < 8; code++) begin
      int e;
      int b2;
      e = exp_of(code);
      wr(1'b1, 3'(code));
      repeat (code + 1) @(negedge clk);
      wr(1'b0, 3'b001);
      base = en_cnt;
      wait_irq(base, (1 << e) - base % M, "R4 first period");
      b2 = en_cnt;
      @(posedge clk); @(negedge clk);
      check(irq == 1'b0, "R3 pulse width", irq, 0);
      wait_irq(b2, 1 << e, "R2 steady period");
    end

    // R5: stop via run bit
    wr(1'b1, 3'd0);
    wr(1'b0, 3'b000);
    c = irq_cnt;
    repeat (200) @(negedge clk);
    check(irq_cnt == c, "R5 run cleared", irq_cnt - c, 0);

    // R6: masked expiries, grid preserved
    wr(1'b0, 3'b001);
    base = en_cnt;
    mask = 1'b1;
    c = irq_cnt;
    repeat (100) @(negedge clk);
    check(irq_cnt == c, "R6 masked", irq_cnt - c, 0);
    mask = 1'b0;
    begin
      int n = 0;
      while (!irq && n < 100) begin @(posedge clk); @(negedge clk); n++; end
      check(irq && ((en_cnt - base - (8 - base % M)) % 8) == 0, "R6 grid after unmask",
            (en_cnt - base - (8 - base % M)) % 8, 0);
    end

    // R7: stop state freezes
    wr(1'b1, 3'd1);
    wr(1'b0, 3'b001);
    base = en_cnt;
    repeat (3) @(negedge clk);
    pwr = 2'b10;
    c = irq_cnt;
    repeat (40) @(negedge clk);
    check(irq_cnt == c, "R7 stop freeze", irq_cnt - c, 0);
    pwr = 2'b00;
    wait_irq(base, 16 - base % M, "R7 stop resume");

    // R7: subsystem clock freezes
    wr(1'b0, 3'b001);
    base = en_cnt;
    repeat (2) @(negedge clk);
    subclk = 1'b1;
    c = irq_cnt;
    repeat (37) @(negedge clk);
    check(irq_cnt == c, "R7 subclk freeze", irq_cnt - c, 0);
    subclk = 1'b0;
    wait_irq(base, 16 - base % M, "R7 subclk resume");

    // R7: code 11 also freezes; halt keeps counting
    wr(1'b0, 3'b001);
    base = en_cnt;
    pwr = 2'b11;
    repeat (30) @(negedge clk);
    pwr = 2'b01;
    wait_irq(base, 16 - base % M, "R7 halt counts");
    pwr = 2'b00;

    // R4: restart mid-period
    wr(1'b1, 3'd3);
    wr(1'b0, 3'b001);
    repeat (41) @(negedge clk);
    wr(1'b0, 3'b001);
    base = en_cnt;
    wait_irq(base, 64 - base % M, "R4 restart");

    // R10: shrink past the new limit
    wr(1'b1, 3'd7);
    wr(1'b0, 3'b001);
    repeat (600) @(negedge clk);
    wr(1'b1, 3'd0);
    base = en_cnt;
    wait_irq(base, M - base % M, "R10 shrink");

    // R8 R9: watchdog mode
    do_reset();
    wr(1'b1, 3'd0);
    wr(1'b0, 3'b011);
    c = irq_cnt;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      wr(1'b0, 3'b001);
    end
    check(ovf == 1'b0, "R9 kicks prevent overflow", ovf, 0);
    base = en_cnt;
    wait_ovf(base, 8 - base % M, "R9 overflow time");
    check(irq_cnt == c, "R8 locked, no request", irq_cnt - c, 0);
    wr(1'b0, 3'b001);
    repeat (30) @(negedge clk);
    check(ovf == 1'b1, "R9 overflow sticky", ovf, 1);
    check(irq_cnt == c, "R9 no request in watchdog", irq_cnt - c, 0);

    // R8: reset restores interval mode
    do_reset();
    @(negedge clk);
    check(ovf == 1'b0, "R8 reset clears overflow", ovf, 0);
    wr(1'b0, 3'b001);
    base = en_cnt;
    wait_irq(base, 8 - base % M, "R8 interval after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule